// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two 16-bit down-counters for a host processor that sees them through an 8-bit bus. The bus is byte-wide only. The first counter reloads itself from a latch and so produces a periodic event. The second counter is a one-shot: it fires once after it is loaded and then keeps counting without a reload. Each counter has an event flag. A flag can be cleared by reading the low byte of its counter, by writing a one to it in the flag register, or by reloading the counter. A level interrupt output is raised while any flag is set whose enable bit is also set.

The counters advance only on cycles where the tick-enable input is high, so a clock-enable divider elsewhere sets the count rate. Each 16-bit value occupies two byte addresses, with the more significant byte at the lower address. The host writes the low byte first. Writing the high byte commits the whole value.

Register offsets (4-bit address):
- 0: timer A count, high byte
- 1: timer A count, low byte
- 2: timer A latch, high byte
- 3: timer A latch, low byte
- 4: timer B count, high byte
- 5: timer B count, low byte
- 6: mode register
- 7: flag register
- 8: enable register

Top module: `ivt_top`

## Requirements
- R1: After reset, both counters read 0xFFFF, the timer A latch reads 0x0000, and the flag, enable and mode registers read 0. The interrupt output is low.
- R2: A counter changes only on a cycle with `tick_en` high, and then by exactly minus one, except at the timer A reload step.
- R3: Timer A runs from its loaded value down to 0, steps to 0xFFFF on the next tick, and loads its latch on the tick after that. A full period is therefore latch + 2 ticks.
- R4: The timer A flag (flag bit 0) is set on the tick at which the counter becomes 0. With mode bit 0 set, this happens in every period. With mode bit 0 clear, it happens only on the first zero after a load. A write to the mode register applies from the next tick on.
- R5: A write to offset 1 changes only the latch low byte and leaves the running count alone. A write to offset 0 does four things: it sets the latch high byte, copies the full latch into the counter, clears flag bit 0 and re-arms the one-shot.
- R6: Offsets 2 and 3 read and write the latch bytes. Reading them changes no flag and no count.
- R7: Reading offset 1 clears flag bit 0. Reading offset 0 leaves it unchanged.
- R8: Timer B takes a low byte staged through a write to offset 5. A write to offset 4 loads {data, staged byte}, clears flag bit 1 and arms the counter. Flag bit 1 is set once, when the count becomes 0. The count then keeps decrementing through 0xFFFF without any reload.
- R9: Reading offset 5 clears flag bit 1. Reading offset 4 leaves it unchanged.
- R10: The flag register (offset 7) returns the timer A flag in bit 0, the timer B flag in bit 1, and the interrupt output in bit 7. Writing a one to bit 0 or bit 1 clears that flag.
- R11: The enable register (offset 8) holds enables in bits 1:0. `irq` is high exactly when some flag and its enable bit are both 1.
- R12: Read data appears on `bus_rdata` one cycle after the cycle with `bus_rd` high. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable strobe for both counters |
| bus_addr | input | 4 | Byte register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The embedded assertions check these on every cycle:
- each counter holds without a tick, steps by one on a tick, and takes the latch after its wrap;
- a load takes the written value;
- each detected zero lands in a set flag;
- a read-clear takes effect;
- flags never appear from nothing.

Only the scenarios of the bench can show the rest:
- the full latch + 2 period;
- the one-shot against the repeating mode, including the mode change taking effect mid-run;
- the side-effect-free latch and high-byte reads;
- timer B wrapping without reload;
- the byte layout of every register at the ports.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned N_TMR  = 2;

   localparam logic [ADDR_W-1:0] A_TA_HI   = 4'd0;
   localparam logic [ADDR_W-1:0] A_TA_LO   = 4'd1;
   localparam logic [ADDR_W-1:0] A_LAT_HI  = 4'd2;
   localparam logic [ADDR_W-1:0] A_LAT_LO  = 4'd3;
   localparam logic [ADDR_W-1:0] A_TB_HI   = 4'd4;
   localparam logic [ADDR_W-1:0] A_TB_LO   = 4'd5;
   localparam logic [ADDR_W-1:0] A_MODE    = 4'd6;
   localparam logic [ADDR_W-1:0] A_FLAGS   = 4'd7;
   localparam logic [ADDR_W-1:0] A_ENABLE  = 4'd8;

   localparam int unsigned IRQ_BIT = 7;

   // timer index 0 reloads from its latch, the others run as one-shots
   function automatic bit tmr_reloads(input int unsigned idx);
      return idx == 0;
   endfunction
endpackage

// File: rtl/ivt_down.sv
module ivt_down #(
   parameter int unsigned CNT_W  = 16,
   parameter bit          RELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             repeat_en,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic             armed_q;

   generate
      if (RELOAD) begin : g_reload
         logic wrap_q;
         assign nxt = wrap_q ? reload_val : cnt_q - 1'b1;

         always_ff @(posedge clk) begin
            if (!rst_n)        wrap_q <= 1'b0;
            else if (load)     wrap_q <= 1'b0;
            else if (tick)     wrap_q <= !wrap_q && (cnt_q == '0);
         end

         AST_RELOAD_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !load && wrap_q) |=> (cnt_q == $past(reload_val))); // R3
         AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !load && !wrap_q) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
      end else begin : g_oneshot
         wire unused_reload = ^reload_val;
         assign nxt = cnt_q - 1'b1;

         AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
      end
   endgenerate

   assign hit = tick && !load && (nxt == '0) && (armed_q || repeat_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         armed_q <= 1'b1;
      end else if (tick) begin
         cnt_q <= nxt;
         if (hit) armed_q <= 1'b0;
      end
   end

   assign cnt = cnt_q;

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q)); // R2
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val))); // R5
   AST_HIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic         ien_we,
   input  logic [N-1:0] ien_d,
   output logic [N-1:0] flags,
   output logic [N-1:0] ien,
   output logic         irq
);
   logic [N-1:0] flags_q;
   logic [N-1:0] ien_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         ien_q   <= '0;
      end else begin
         flags_q <= (flags_q & ~clr) | set;
         if (ien_we) ien_q <= ien_d;
      end
   end

   assign flags = flags_q;
   assign ien   = ien_q;
   assign irq   = |(flags_q & ien_q);

   AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q == '0 && set == '0) |=> (flags_q == '0)); // R10

   generate
      for (genvar i = 0; i < N; i++) begin : g_chk
         AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags_q[i]); // R4
         AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags_q[i]); // R7
      end
   endgenerate
endmodule

// File: rtl/ivt_top.sv
module ivt_top #(
   parameter int unsigned CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic [3:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq
);
   import ivt_pkg::*;

   localparam int unsigned HI_W = CNT_W - BYTE_W;

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         $error("ivt_top: CNT_W must lie in 9..16");
      end
   endgenerate

   logic [CNT_W-1:0] lat_q;
   logic [BYTE_W-1:0] tb_stage_q;
   logic             rpt_q;

   logic [N_TMR-1:0] ld;
   logic [N_TMR-1:0] hit;
   logic [N_TMR-1:0] rd_clr;
   logic [N_TMR-1:0] wr_clr;
   logic [N_TMR-1:0] flags;
   logic [N_TMR-1:0] ien;
   logic [CNT_W-1:0] cnt   [N_TMR];
   logic [CNT_W-1:0] ldval [N_TMR];
   logic [BYTE_W-1:0] rdata_q;

   wire wr_ta_hi = bus_wr && bus_addr == A_TA_HI;

   // timer A load value: new high byte joined to the held low latch byte
   assign ldval[0] = {bus_wdata[HI_W-1:0], lat_q[BYTE_W-1:0]};
   assign ldval[1] = {bus_wdata[HI_W-1:0], tb_stage_q};
   assign ld[0]    = wr_ta_hi;
   assign ld[1]    = bus_wr && bus_addr == A_TB_HI;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q      <= '0;
         tb_stage_q <= '0;
         rpt_q      <= 1'b0;
      end else if (bus_wr) begin
         unique case (bus_addr)
            A_TA_HI, A_LAT_HI: lat_q[CNT_W-1:BYTE_W] <= bus_wdata[HI_W-1:0];
            A_TA_LO, A_LAT_LO: lat_q[BYTE_W-1:0]     <= bus_wdata;
            A_TB_LO:           tb_stage_q            <= bus_wdata;
            A_MODE:            rpt_q                 <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
         ivt_down #(.CNT_W(CNT_W), .RELOAD(tmr_reloads(i))) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick_en),
            .load       (ld[i]),
            .load_val   (ldval[i]),
            .reload_val (lat_q),
            .repeat_en  (tmr_reloads(i) ? rpt_q : 1'b0),
            .cnt        (cnt[i]),
            .hit        (hit[i])
         );
      end
   endgenerate

   assign rd_clr[0] = bus_rd && bus_addr == A_TA_LO;
   assign rd_clr[1] = bus_rd && bus_addr == A_TB_LO;
   assign wr_clr    = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[N_TMR-1:0] : '0;

   ivt_irq #(.N(N_TMR)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (hit),
      .clr    (rd_clr | wr_clr | ld),
      .ien_we (bus_wr && bus_addr == A_ENABLE),
      .ien_d  (bus_wdata[N_TMR-1:0]),
      .flags  (flags),
      .ien    (ien),
      .irq    (irq)
   );

   function automatic logic [BYTE_W-1:0] hi_byte(input logic [CNT_W-1:0] v);
      logic [15:0] w;
      w = 16'(v);
      return w[15:8];
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         unique case (bus_addr)
            A_TA_HI:  rdata_q <= hi_byte(cnt[0]);
            A_TA_LO:  rdata_q <= cnt[0][BYTE_W-1:0];
            A_LAT_HI: rdata_q <= hi_byte(lat_q);
            A_LAT_LO: rdata_q <= lat_q[BYTE_W-1:0];
            A_TB_HI:  rdata_q <= hi_byte(cnt[1]);
            A_TB_LO:  rdata_q <= cnt[1][BYTE_W-1:0];
            A_MODE:   rdata_q <= {7'd0, rpt_q};
            A_FLAGS:  rdata_q <= {irq, {(IRQ_BIT-N_TMR){1'b0}}, flags};
            A_ENABLE: rdata_q <= {{(BYTE_W-N_TMR){1'b0}}, ien};
            default:  rdata_q <= '0;
         endcase
      end
   end

   assign bus_rdata = rdata_q;

   AST_HIGH_WRITE_KEEPS_LOW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ta_hi |=> (lat_q[BYTE_W-1:0] == $past(lat_q[BYTE_W-1:0]))); // R5
   AST_HIGH_READ_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_TA_HI && flags[0] && !bus_wr) |=> flags[0]); // R7
endmodule

// File: tb/tb_ivt_top.sv
module tb_ivt_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   ivt_top dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // driver: queue the expected byte, then issue the read
   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      exp_q.push_back(e); tag_q.push_back(tag);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: irq=%0b expected %0b", tag, irq, e);
      end
   endtask

   // monitor: one result per read, compared a cycle after the strobe
   initial begin
      forever begin
         @(posedge clk);
         if (bus_rd) begin
            @(negedge clk);
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R12: read data %02h with no expected item", bus_rdata);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (bus_rdata !== e) begin
                  errors++;
                  $display("FAIL %s: rdata=%02h expected %02h", t, bus_rdata, e);
               end
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run incomplete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(4'd0, 8'hFF, "R1 ta hi");
      rd(4'd1, 8'hFF, "R1 ta lo");
      rd(4'd4, 8'hFF, "R1 tb hi");
      rd(4'd5, 8'hFF, "R1 tb lo");
      rd(4'd7, 8'h00, "R1 flags");
      rd(4'd8, 8'h00, "R1 enables");
      rd(4'd6, 8'h00, "R1 mode");
      rd(4'd2, 8'h00, "R1 latch hi");
      rd(4'd3, 8'h00, "R1 latch lo");
      chk_irq(1'b0, "R1 irq");

      // timer A load and repeat mode
      wr(4'd1, 8'd5);
      wr(4'd0, 8'd0);
      wr(4'd6, 8'd1);
      rd(4'd1, 8'd5, "R5 load lo");
      rd(4'd0, 8'd0, "R5 load hi");
      ticks(2);
      rd(4'd1, 8'd3, "R2 two ticks");
      rd(4'd1, 8'd3, "R2 hold without tick");
      ticks(3);
      rd(4'd7, 8'h01, "R4 flag at zero");
      rd(4'd0, 8'h00, "R7 hi read");
      rd(4'd7, 8'h01, "R7 hi read keeps flag");
      rd(4'd2, 8'h00, "R6 latch hi");
      rd(4'd3, 8'h05, "R6 latch lo");
      rd(4'd7, 8'h01, "R6 latch reads no side effect");
      ticks(1);
      rd(4'd0, 8'hFF, "R3 step to FFFF hi");
      rd(4'd1, 8'hFF, "R3 step to FFFF lo");
      rd(4'd7, 8'h00, "R7 lo read clears");
      ticks(1);
      rd(4'd1, 8'd5, "R3 reload after wrap");
      wr(4'd1, 8'd9);
      rd(4'd1, 8'd5, "R5 lo write leaves count");
      rd(4'd3, 8'd9, "R5 lo write sets latch");
      ticks(5);
      wr(4'd8, 8'h01);
      chk_irq(1'b1, "R11 enabled flag");
      rd(4'd7, 8'h81, "R10 irq in bit7");
      wr(4'd8, 8'h00);
      chk_irq(1'b0, "R11 disabled flag");
      wr(4'd7, 8'h01);
      rd(4'd7, 8'h00, "R10 write one clears");
      ticks(2);
      rd(4'd1, 8'd9, "R3 period latch+2");

      // one-shot mode then immediate switch
      wr(4'd6, 8'd0);
      wr(4'd0, 8'd0);
      ticks(9);
      rd(4'd7, 8'h01, "R4 one-shot first zero");
      wr(4'd7, 8'h01);
      ticks(11);
      rd(4'd1, 8'd0, "R3 second zero");
      rd(4'd7, 8'h00, "R4 one-shot no refire");
      wr(4'd6, 8'd1);
      ticks(11);
      rd(4'd7, 8'h01, "R4 mode change immediate");
      wr(4'd0, 8'd0);
      rd(4'd7, 8'h00, "R5 load clears flag");
      rd(4'd1, 8'd9, "R5 load copies latch");

      // timer B one-shot
      wr(4'd5, 8'd3);
      wr(4'd4, 8'd0);
      rd(4'd5, 8'd3, "R8 tb load");
      ticks(3);
      rd(4'd7, 8'h02, "R8 tb flag");
      rd(4'd4, 8'h00, "R9 tb hi read");
      rd(4'd7, 8'h02, "R9 hi read keeps flag");
      rd(4'd5, 8'h00, "R9 lo read");
      rd(4'd7, 8'h00, "R9 lo read clears");
      ticks(4);
      rd(4'd4, 8'hFF, "R8 wraps hi");
      rd(4'd5, 8'hFC, "R8 no reload");
      rd(4'd7, 8'h00, "R8 no second flag");
      wr(4'd8, 8'h02);
      chk_irq(1'b0, "R11 enable without flag");
      rd(4'd8, 8'h02, "R11 enable readback");
      rd(4'hF, 8'h00, "R12 unmapped");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule